// File: doc/BRIEF.md
# Masked Associative Word Array

This block keeps a small bank of data words. Each word has one response bit, and together those bits form a response vector. A controller broadcasts one operation per cycle, and every word evaluates it in the same cycle.

Operations come in two kinds:
- A **search** tests a predicate on each word and ANDs the result into that word's response bit. Repeated searches therefore narrow the active set.
- A **transform** rewrites only the words whose response bit is 1. The other words keep their values.

In this way, nested conditional work is expressed entirely as masking by the response vector.

The controller can see at once when no word remains active, through a flag that is high when the whole response vector is zero. The controller can also overwrite the response vector directly, which restores a mask it saved earlier. A plain per-word write port fills the words.

The asynchronous reset input is released into the array through a two-stage synchronizer. The array leaves reset two clock edges after `rst_n` rises.

Top module: `assoc_mask_array`

## Requirements
- R1: After reset, every word is 0, every response bit is 1 and `none_o` is 0.
- R2: A search ANDs a predicate into each response bit and leaves every word unchanged. Code 3'b000 tests "word < 3" and code 3'b001 tests "word == 3". A search can clear response bits but never set them.
- R3: A transform rewrites each word whose response bit is 1 and leaves the response vector unchanged. The transform codes are:
  - 3'b010: clear to 0
  - 3'b011: decrement by 1
  - 3'b100: increment by 1
  - 3'b101: multiply by 2
- R4: During a transform, a word whose response bit is 0 keeps its old value.
- R5: Arithmetic wraps modulo 2^WORD_W. Decrementing 0 gives 255, incrementing 255 gives 0, and multiply by 2 is a left shift that drops the MSB (8'h81 becomes 8'h02).
- R6: `none_o` is high in exactly the cycles where all response bits are 0, and it follows the response vector with no added register.
- R7: When `rsp_load` is high, the response vector takes `rsp_load_val` (bit j goes to word j) on the next edge. Any operation issued in the same cycle is discarded.
- R8: Codes 3'b110 and 3'b111 change neither the words nor the response vector.
- R9: When `wr_en` is high, word `wr_idx` takes `wr_data` on the next edge. In that same cycle, the write overrides a transform on that word, and the other words are still transformed.
- R10: When `op_valid`, `rsp_load` and `wr_en` are all low, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| rsp_load | input | 1 | Load the response vector |
| rsp_load_val | input | N_WORDS | Value to load; bit j belongs to word j |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | $clog2(N_WORDS) | Index of the word to write |
| wr_data | input | WORD_W | Data to write |
| words_o | output | N_WORDS*WORD_W | All words; word j is at bits [j*WORD_W +: WORD_W] |
| rsp_o | output | N_WORDS | Response vector |
| none_o | output | 1 | High when the response vector is all zero |

## Verification
The hardest situations to reach from the ports are the ones where two controls meet in a single cycle:
- a response load arriving together with an operation;
- a word write arriving together with a transform that covers the same word.

The directed tasks set up such collisions on purpose. Before each one they first load a known response mask, so that the ignored path would produce a visible difference.

The wrap corners need specific word values under a narrow mask. To reach them, each such word is written with the port write and then selected alone through a response load.

// File: rtl/assoc_mask_pkg.sv
package assoc_mask_pkg;
  typedef enum logic [2:0] {
    OP_LT3 = 3'd0,
    OP_EQ3 = 3'd1,
    OP_CLR = 3'd2,
    OP_DEC = 3'd3,
    OP_INC = 3'd4,
    OP_DBL = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } am_op_e;

  function automatic logic am_is_search(am_op_e op);
    return (op == OP_LT3) || (op == OP_EQ3);
  endfunction

  function automatic logic am_is_xform(am_op_e op);
    return (op == OP_CLR) || (op == OP_DEC) || (op == OP_INC) || (op == OP_DBL);
  endfunction
endpackage

// File: rtl/assoc_mask_cell.sv
module assoc_mask_cell
  import assoc_mask_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  am_op_e            op_code,
  input  logic              rsp_load,
  input  logic              rsp_load_bit,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q,
  output logic              rsp_q
);
  logic              op_go;
  logic              pred;
  logic              rsp_en;
  logic              rsp_d;
  logic              word_en;
  logic [WORD_W-1:0] xf;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    op_go = op_valid & ~rsp_load;
    pred  = (op_code == OP_LT3) ? (word_q < WORD_W'(3)) : (word_q == WORD_W'(3));
    rsp_en = rsp_load | (op_go & am_is_search(op_code));
    rsp_d  = rsp_load ? rsp_load_bit : (rsp_q & pred);
    unique case (op_code)
      OP_CLR:  xf = '0;
      OP_DEC:  xf = word_q - WORD_W'(1);
      OP_INC:  xf = word_q + WORD_W'(1);
      OP_DBL:  xf = {word_q[WORD_W-2:0], 1'b0};
      default: xf = word_q;
    endcase
    word_en = wr_hit | (op_go & am_is_xform(op_code) & rsp_q);
    word_d  = wr_hit ? wr_data : xf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= 1'b1;
      word_q <= '0;
    end else begin
      if (rsp_en)  rsp_q  <= rsp_d;
      if (word_en) word_q <= word_d;
    end
  end

  a_r2_search_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rsp_load && am_is_search(op_code)) |=> !(rsp_q && !$past(rsp_q)));
  a_r4_masked_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rsp_load && !wr_hit && !rsp_q) |=> $stable(word_q));
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> (rsp_q == $past(rsp_load_bit)));
  a_r8_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rsp_load && !wr_hit && (op_code == OP_RS6 || op_code == OP_RS7))
    |=> ($stable(word_q) && $stable(rsp_q)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !rsp_load && !wr_hit) |=> ($stable(word_q) && $stable(rsp_q)));
endmodule

// File: rtl/assoc_mask_none.sv
module assoc_mask_none #(
  parameter int N_WORDS = 8
) (
  input  logic [N_WORDS-1:0] rsp,
  output logic               none
);
  assign none = ~|rsp;
endmodule

// File: rtl/assoc_mask_array.sv
module assoc_mask_array
  import assoc_mask_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 8,
  localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic                       rsp_load,
  input  logic [N_WORDS-1:0]         rsp_load_val,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [N_WORDS*WORD_W-1:0]  words_o,
  output logic [N_WORDS-1:0]         rsp_o,
  output logic                       none_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  am_op_e     op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];
  assign op_e       = am_op_e'(op_code);

  for (genvar g = 0; g < N_WORDS; g++) begin : g_cell
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic hit;
    assign hit = wr_en && (wr_idx == MY_IDX);
    assoc_mask_cell #(.WORD_W(WORD_W)) u_cell (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .op_valid     (op_valid),
      .op_code      (op_e),
      .rsp_load     (rsp_load),
      .rsp_load_bit (rsp_load_val[g]),
      .wr_hit       (hit),
      .wr_data      (wr_data),
      .word_q       (words_o[g*WORD_W +: WORD_W]),
      .rsp_q        (rsp_o[g])
    );
  end

  assoc_mask_none #(.N_WORDS(N_WORDS)) u_none (
    .rsp  (rsp_o),
    .none (none_o)
  );

  a_r6_none_matches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    none_o == ($countones(rsp_o) == 0));
  a_r3_xform_keeps_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !rsp_load && am_is_xform(op_e)) |=> $stable(rsp_o));
endmodule

// File: tb/assoc_mask_array_bench.sv
module assoc_mask_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic          rsp_load = 1'b0;
  logic [N-1:0]  rsp_load_val = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [W-1:0]  wr_data = '0;
  logic [N*W-1:0] words_o;
  logic [N-1:0]  rsp_o;
  logic          none_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [W-1:0] m_w [N];
  logic [N-1:0] m_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_mask_array #(.N_WORDS(N), .WORD_W(W)) u_assoc_mask_array (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .rsp_load(rsp_load), .rsp_load_val(rsp_load_val), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .words_o(words_o), .rsp_o(rsp_o),
    .none_o(none_o)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int j = 0; j < N; j++) chk(req, $sformatf("word%0d", j), words_o[j*W +: W], m_w[j]);
    chk(req, "rsp", rsp_o, m_r);
    chk(req, "none", {7'd0, none_o}, {7'd0, (m_r == '0)});
  endtask

  // One cycle of stimulus: drive at the falling edge, clock, then sample at the next falling edge.
  // The model applies the requirements to predict the new state.
  task automatic cyc(input logic v, input logic [2:0] c, input logic ld, input logic [N-1:0] lv,
                     input logic we, input logic [2:0] wi, input logic [W-1:0] wd);
    logic [W-1:0] nw [N];
    logic [N-1:0] nr;
    op_valid = v; op_code = c; rsp_load = ld; rsp_load_val = lv;
    wr_en = we; wr_idx = wi; wr_data = wd;
    nr = m_r;
    for (int j = 0; j < N; j++) nw[j] = m_w[j];
    if (ld) nr = lv;
    else if (v) begin
      for (int j = 0; j < N; j++) begin
        case (c)
          3'd0: nr[j] = m_r[j] & (m_w[j] < 3);
          3'd1: nr[j] = m_r[j] & (m_w[j] == 3);
          3'd2: if (m_r[j]) nw[j] = 8'd0;
          3'd3: if (m_r[j]) nw[j] = m_w[j] - 8'd1;
          3'd4: if (m_r[j]) nw[j] = m_w[j] + 8'd1;
          3'd5: if (m_r[j]) nw[j] = m_w[j] << 1;
          default: ;
        endcase
      end
    end
    if (we) nw[wi] = wd;
    @(posedge clk);
    @(negedge clk);
    m_r = nr;
    for (int j = 0; j < N; j++) m_w[j] = nw[j];
    op_valid = 0; rsp_load = 0; wr_en = 0;
  endtask

  task automatic t_reset;
    for (int j = 0; j < N; j++) m_w[j] = '0;
    m_r = '1;
    check_all("R1");
  endtask

  task automatic t_write;
    logic [W-1:0] vals [N] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'hFF, 8'h81, 8'd3};
    for (int j = 0; j < N; j++) cyc(0, 0, 0, '0, 1, 3'(j), vals[j]);
    check_all("R9");
  endtask

  task automatic t_search;
    cyc(1, 3'd0, 0, '0, 0, 0, 0); check_all("R2");
    chk("R2", "lt3 mask", rsp_o, 8'b0000_0111);
    cyc(1, 3'd1, 0, '0, 0, 0, 0); check_all("R6");
    chk("R6", "none high", {7'd0, none_o}, 8'd1);
    cyc(1, 3'd1, 1, 8'hFF, 0, 0, 0);
    cyc(1, 3'd1, 0, '0, 0, 0, 0); check_all("R2");
    chk("R2", "eq3 mask", rsp_o, 8'b1000_1000);
  endtask

  task automatic t_xform;
    cyc(0, 0, 1, 8'b0010_0000, 0, 0, 0);
    cyc(1, 3'd4, 0, '0, 0, 0, 0); check_all("R5");
    chk("R5", "inc wrap", words_o[5*W +: W], 8'h00);
    cyc(0, 0, 1, 8'b0000_0001, 0, 0, 0);
    cyc(1, 3'd3, 0, '0, 0, 0, 0); check_all("R5");
    chk("R5", "dec wrap", words_o[0 +: W], 8'hFF);
    cyc(0, 0, 1, 8'b0100_0000, 0, 0, 0);
    cyc(1, 3'd5, 0, '0, 0, 0, 0); check_all("R5");
    chk("R5", "dbl drop msb", words_o[6*W +: W], 8'h02);
    cyc(0, 0, 1, 8'b0001_0100, 0, 0, 0);
    cyc(1, 3'd2, 0, '0, 0, 0, 0); check_all("R3");
    chk("R4", "unmasked word1 kept", words_o[1*W +: W], 8'd1);
    cyc(1, 3'd4, 0, '0, 0, 0, 0); check_all("R4");
  endtask

  task automatic t_load_priority;
    cyc(0, 0, 1, 8'hFF, 0, 0, 0);
    cyc(1, 3'd2, 1, 8'hF0, 0, 0, 0); check_all("R7");
    cyc(1, 3'd0, 1, 8'h3C, 0, 0, 0); check_all("R7");
  endtask

  task automatic t_reserved;
    cyc(0, 0, 1, 8'hFF, 0, 0, 0);
    cyc(1, 3'd6, 0, '0, 0, 0, 0); check_all("R8");
    cyc(1, 3'd7, 0, '0, 0, 0, 0); check_all("R8");
  endtask

  task automatic t_idle;
    op_code = 3'd2;
    cyc(0, 3'd2, 0, 8'h00, 0, 0, 0); check_all("R10");
  endtask

  task automatic t_write_vs_xform;
    cyc(0, 0, 1, 8'hFF, 0, 0, 0);
    cyc(1, 3'd4, 0, '0, 1, 3'd2, 8'h55); check_all("R9");
    chk("R9", "write wins", words_o[2*W +: W], 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_search();
    t_xform();
    t_load_priority();
    t_reserved();
    t_idle();
    t_write_vs_xform();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule